// File: doc/BRIEF.md
# Watchdog-Capable Compare Timer

This block is a 16-bit up-counter paced by a power-of-two prescaler. The prescaler counts enable pulses from one of two tick inputs, chosen by a select bit in the configuration word. Two compare units watch the counter. Each one has its own mode and raises a status flag when its condition holds on a counter step. The counter returns to zero on the step where it equals the second compare value, so that value sets the period.

Software reaches four 16-bit registers through a simple word-select bus: compare 1, compare 2, the counter and the setup word. The setup word is a write-once configuration. The first write loads it and sets a lock bit, and any later write can only clear status flags. When the external watchdog enable is high and the counter meets compare 2, the block raises a reset request. The request stays up until the enable is lowered. Writing 0 to the counter restarts the period, which is how software services the watchdog.

Top module: `wdt_timer`

## Requirements
- R1: `bus_rdata` shows, one clock after `reg_sel` is presented, the register selected by it: 0 = compare 1, 1 = compare 2, 2 = counter, 3 = setup word (byte offsets 0x0, 0x2, 0x4, 0x6).
- R2: Setup word layout: bits 3:0 divide exponent, bit 4 tick select, bit 5 reverse enable (stored only), bits 7:6 compare-1 mode, bits 9:8 compare-2 mode, bit 11 stop enable (stored only), bit 12 lock, bit 13 compare-1 flag, bit 14 compare-2 flag, bit 15 run, bit 10 reads 0. The first setup write loads bits 11:0 and 15 and sets the lock bit. Later writes leave those bits unchanged.
- R3: While run is set, the counter takes one step per 2^exponent selected tick pulses. While run is clear, the counter does not move.
- R4: Tick select 0 paces the prescaler from `tick_a`, and 1 paces it from `tick_b`. The other input has no effect.
- R5: On a step where the counter equals compare 2 it becomes 0. Otherwise it increments modulo 2^16.
- R6: A counter write loads the written value and zeroes the prescaler phase. It takes precedence over a step in the same cycle.
- R7: Mode 1 (equal) sets the flag on a step where the counter, before the step, equals the compare value. The flag then holds.
- R8: Mode 2 (greater-or-equal) sets the flag on every step where the counter is at or above the compare value. The flag then holds.
- R9: Mode 3 (event) makes the flag, on every step, equal to whether that step matched. Between steps it holds.
- R10: Mode 0 never sets the flag.
- R11: Writing the setup word with bit 13 or bit 14 at 1 clears that flag. A set condition in the same cycle wins.
- R12: `reset_req` rises after a step with the counter equal to compare 2 while `wdt_rst_en` is high. It holds while the enable stays high and falls one clock after the enable is low.
- R13: After reset every register, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (word index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tick_a | input | 1 | Tick enable source 0 |
| tick_b | input | 1 | Tick enable source 1 |
| wdt_rst_en | input | 1 | Allows compare-2 matches to request reset |
| cmp1_flag | output | 1 | Compare-1 status flag |
| cmp2_flag | output | 1 | Compare-2 status flag |
| reset_req | output | 1 | Registered reset request |

## Verification
A constant tick on one source with a zero exponent drives the counter every cycle. This shows the wrap at compare 2 and separates the equal, greater-or-equal, event and disabled modes by how long each flag stays high. A tick on the unselected source with an exponent of two shows that the select bit and the divider work. A counter write placed mid-phase shows that the prescaler phase restarts. A long random run, with writes mixed among tick patterns and enable toggles, is compared against a behavioural model every clock. That run catches ordering faults between writes, steps and flag clears that the directed cases do not hit.

// File: rtl/wdt_timer_pkg.sv
package wdt_timer_pkg;
  localparam int WORD_W = 16;
  localparam int DIV_W  = 4;
  localparam int SLOT_N = 4;
  localparam int SEL_W  = 2;
  localparam int PRE_W  = (1 << DIV_W) - 1;

  localparam logic [SEL_W-1:0] SLOT_CMP1  = 2'd0;
  localparam logic [SEL_W-1:0] SLOT_CMP2  = 2'd1;
  localparam logic [SEL_W-1:0] SLOT_COUNT = 2'd2;
  localparam logic [SEL_W-1:0] SLOT_SETUP = 2'd3;

  localparam int B_STOP = 11;
  localparam int B_LOCK = 12;
  localparam int B_F1   = 13;
  localparam int B_F2   = 14;
  localparam int B_RUN  = 15;

  typedef enum logic [1:0] {
    CMP_OFF = 2'd0,
    CMP_EQ  = 2'd1,
    CMP_GE  = 2'd2,
    CMP_EVT = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic             run;
    logic             stop_en;
    cmp_mode_e        mode2;
    cmp_mode_e        mode1;
    logic             rev;
    logic             clk_sel;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.run     = w[B_RUN];
    c.stop_en = w[B_STOP];
    c.mode2   = cmp_mode_e'(w[9:8]);
    c.mode1   = cmp_mode_e'(w[7:6]);
    c.rev     = w[5];
    c.clk_sel = w[4];
    c.div     = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_from_cfg(input cfg_t c, input logic lock,
                                                      input logic f1, input logic f2);
    return {c.run, f2, f1, lock, c.stop_en, 1'b0, c.mode2, c.mode1, c.rev, c.clk_sel, c.div};
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV_W = 4,
  parameter int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] last;

  assign last = ~({PRE_W{1'b1}} << div);
  assign tick = run & src & (phase == last);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) phase <= '0;
    else if (run && src)        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wdt_compare.sv
module wdt_compare
  import wdt_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] limit,
  input  cmp_mode_e mode,
  input  logic      clear,
  output logic      flag
);
  logic eq_hit;
  logic ge_hit;
  logic kept;

  assign eq_hit = (count == limit);
  assign ge_hit = (count >= limit);
  assign kept   = flag & ~clear;

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else begin
      unique case (mode)
        CMP_OFF: flag <= kept;
        CMP_EQ:  flag <= kept | (tick & eq_hit);
        CMP_GE:  flag <= kept | (tick & ge_hit);
        CMP_EVT: flag <= tick ? eq_hit : kept;
        default: flag <= kept;
      endcase
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              wdt_rst_en,
  output logic              cmp1_flag,
  output logic              cmp2_flag,
  output logic              reset_req
);
  localparam int NUM_CMP = 2;

  logic [SLOT_N-1:0]  wr_hit;
  logic               cnt_wr;
  logic               setup_wr;
  logic               src;
  logic               tick;
  logic               wrap_hit;
  logic               locked;
  cfg_t               cfg;
  logic [WORD_W-1:0]  count;
  logic [WORD_W-1:0]  cmp1_val;
  logic [WORD_W-1:0]  cmp2_val;
  logic [WORD_W-1:0]  limit_v [NUM_CMP];
  cmp_mode_e          mode_v  [NUM_CMP];
  logic [NUM_CMP-1:0] flag_v;

  assign wr_hit   = bus_wr ? (SLOT_N'(1) << reg_sel) : '0;
  assign cnt_wr   = wr_hit[SLOT_COUNT];
  assign setup_wr = wr_hit[SLOT_SETUP];
  assign src      = cfg.clk_sel ? tick_b : tick_a;
  assign wrap_hit = tick & (count == cmp2_val);

  wdt_prescale #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(cfg.run), .src(src), .div(cfg.div),
    .restart(cnt_wr), .tick(tick)
  );

  assign limit_v[0] = cmp1_val;
  assign limit_v[1] = cmp2_val;
  assign mode_v[0]  = cfg.mode1;
  assign mode_v[1]  = cfg.mode2;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    wdt_compare #(.W(WORD_W)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick), .count(count),
      .limit(limit_v[g]), .mode(mode_v[g]),
      .clear(setup_wr & bus_wdata[B_F1+g]), .flag(flag_v[g])
    );
  end

  assign cmp1_flag = flag_v[0];
  assign cmp2_flag = flag_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      cmp1_val <= '0;
      cmp2_val <= '0;
      cfg      <= '0;
      locked   <= 1'b0;
    end else begin
      if (cnt_wr)    count <= bus_wdata;
      else if (tick) count <= (count == cmp2_val) ? '0 : count + 1'b1;
      if (wr_hit[SLOT_CMP1]) cmp1_val <= bus_wdata;
      if (wr_hit[SLOT_CMP2]) cmp2_val <= bus_wdata;
      if (setup_wr && !locked) begin
        cfg    <= cfg_from_word(bus_wdata);
        locked <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !wdt_rst_en) reset_req <= 1'b0;
    else if (wrap_hit)      reset_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (reg_sel)
        SLOT_CMP1:  bus_rdata <= cmp1_val;
        SLOT_CMP2:  bus_rdata <= cmp2_val;
        SLOT_COUNT: bus_rdata <= count;
        default:    bus_rdata <= word_from_cfg(cfg, locked, flag_v[0], flag_v[1]);
      endcase
    end
  end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk
  import wdt_timer_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wdt_rst_en,
  input logic              reset_req,
  input logic              tick,
  input logic              cnt_wr,
  input logic              setup_wr,
  input logic              locked,
  input logic [WORD_W-1:0] count,
  input logic [WORD_W-1:0] cmp2_val,
  input cfg_t              cfg,
  input logic              cmp1_flag
);
  assert_req_needs_en_R12: assert property (@(posedge clk) disable iff (rst)
    !wdt_rst_en |=> !reset_req);

  assert_req_holds_R12: assert property (@(posedge clk) disable iff (rst)
    reset_req && wdt_rst_en |=> reset_req);

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_wr && (count == cmp2_val) |=> (count == '0));

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    locked && setup_wr |=> (cfg == $past(cfg)));

  assert_count_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !tick && !cnt_wr |=> $stable(count));

  assert_off_mode_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode1 == CMP_OFF) && !cmp1_flag |=> !cmp1_flag);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst(rst), .wdt_rst_en(wdt_rst_en), .reset_req(reset_req),
  .tick(tick), .cnt_wr(cnt_wr), .setup_wr(setup_wr), .locked(locked),
  .count(count), .cmp2_val(cmp2_val), .cfg(cfg), .cmp1_flag(cmp1_flag)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        tick_a = 1'b0;
  logic        tick_b = 1'b0;
  logic        wdt_rst_en = 1'b0;
  logic        cmp1_flag, cmp2_flag, reset_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit live    = 0;
  bit done    = 0;
  string cur_req = "R13";
  logic [1:0] view = 2'd0;

  always #4 clk = ~clk;

  wdt_timer i_wdt_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .reg_sel(reg_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_a(tick_a), .tick_b(tick_b), .wdt_rst_en(wdt_rst_en),
    .cmp1_flag(cmp1_flag), .cmp2_flag(cmp2_flag), .reset_req(reset_req)
  );

  // behavioural reference model
  int m_c1, m_c2, m_cnt, m_pre, m_rdata;
  int m_div, m_sel, m_rev, m_m1, m_m2, m_stop, m_run, m_lock, m_f1, m_f2, m_req;
  int t_src, t_tk, t_f1, t_f2, t_w;

  function automatic int flag_step(int mode, int f, int clr, int tk, int cnt, int lim);
    int kept = clr ? 0 : f;
    case (mode)
      1: return (tk != 0 && cnt == lim) ? 1 : kept;
      2: return (tk != 0 && cnt >= lim) ? 1 : kept;
      3: return (tk != 0) ? ((cnt == lim) ? 1 : 0) : kept;
      default: return kept;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_c1 = 0; m_c2 = 0; m_cnt = 0; m_pre = 0; m_rdata = 0;
      m_div = 0; m_sel = 0; m_rev = 0; m_m1 = 0; m_m2 = 0; m_stop = 0;
      m_run = 0; m_lock = 0; m_f1 = 0; m_f2 = 0; m_req = 0;
    end else begin
      t_src = m_sel ? tick_b : tick_a;
      t_tk  = (m_run != 0 && t_src != 0 && m_pre == (1 << m_div) - 1) ? 1 : 0;
      t_w   = bus_wdata;
      case (reg_sel)
        2'd0: m_rdata = m_c1;
        2'd1: m_rdata = m_c2;
        2'd2: m_rdata = m_cnt;
        default: m_rdata = (m_run << 15) | (m_f2 << 14) | (m_f1 << 13) | (m_lock << 12) |
                           (m_stop << 11) | (m_m2 << 8) | (m_m1 << 6) | (m_rev << 5) |
                           (m_sel << 4) | m_div;
      endcase
      t_f1 = flag_step(m_m1, m_f1, (bus_wr && reg_sel == 3 && t_w[13]) ? 1 : 0, t_tk, m_cnt, m_c1);
      t_f2 = flag_step(m_m2, m_f2, (bus_wr && reg_sel == 3 && t_w[14]) ? 1 : 0, t_tk, m_cnt, m_c2);
      if (!wdt_rst_en) m_req = 0;
      else if (t_tk != 0 && m_cnt == m_c2) m_req = 1;
      if (bus_wr && reg_sel == 2) begin
        m_cnt = t_w; m_pre = 0;
      end else if (t_tk != 0) begin
        m_cnt = (m_cnt == m_c2) ? 0 : (m_cnt + 1) % 65536; m_pre = 0;
      end else if (m_run != 0 && t_src != 0) m_pre++;
      m_f1 = t_f1; m_f2 = t_f2;
      if (bus_wr && reg_sel == 0) m_c1 = t_w;
      if (bus_wr && reg_sel == 1) m_c2 = t_w;
      if (bus_wr && reg_sel == 3 && m_lock == 0) begin
        m_div = t_w & 15; m_sel = (t_w >> 4) & 1; m_rev = (t_w >> 5) & 1;
        m_m1 = (t_w >> 6) & 3; m_m2 = (t_w >> 8) & 3; m_stop = (t_w >> 11) & 1;
        m_run = (t_w >> 15) & 1; m_lock = 1;
      end
    end
    live = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      chk({cur_req, " rdata"}, bus_rdata, m_rdata);
      chk({cur_req, " flag1"}, cmp1_flag, m_f1);
      chk({cur_req, " flag2"}, cmp2_flag, m_f2);
      chk({cur_req, " reset_req"}, reset_req, m_req);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; reg_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; reg_sel = view;
  endtask

  task automatic look(input logic [1:0] sel);
    view = sel; reg_sel = sel;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_a = 1'b0; tick_b = 1'b0; wdt_rst_en = 1'b0; bus_wr = 1'b0;
    idle(2);
    rst = 1'b0;
  endtask

  int maxc, saw0, pulses;

  initial begin
    do_reset();
    // R13: reset values
    cur_req = "R13";
    for (int s = 0; s < 4; s++) begin
      look(2'(s)); idle(2);
      chk("R13 register after reset", bus_rdata, 0);
    end
    chk("R13 flags", {cmp1_flag, cmp2_flag, reset_req}, 0);

    // R7 / R5 / R2 / R11: equal mode, period via compare 2
    cur_req = "R7";
    wr(2'd0, 16'd5); wr(2'd1, 16'd9);
    look(2'd2);
    wr(2'd3, 16'h8040);
    tick_a = 1'b1;
    idle(30);
    chk("R7 equal flag set", cmp1_flag, 1);
    cur_req = "R5";
    maxc = 0; saw0 = 0;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      if (bus_rdata > maxc) maxc = bus_rdata;
      if (bus_rdata == 0) saw0 = 1;
    end
    chk("R5 counter peak equals compare 2", maxc, 9);
    chk("R5 counter wraps to zero", saw0, 1);
    cur_req = "R2";
    wr(2'd3, 16'h0003);
    look(2'd3); idle(2);
    chk("R2 config kept after second write", bus_rdata & 16'h9fff, 16'h9040);
    cur_req = "R11";
    tick_a = 1'b0; idle(1);
    wr(2'd3, 16'h2000);
    idle(1);
    chk("R11 flag1 cleared by write-one", cmp1_flag, 0);
    tick_a = 1'b1; idle(20);
    chk("R11 flag1 sets again at next match", cmp1_flag, 1);

    // R3 / R4: divide by 4 paced from tick_b
    do_reset();
    cur_req = "R4";
    look(2'd2);
    wr(2'd1, 16'hffff);
    wr(2'd3, 16'h8012);
    tick_a = 1'b1; idle(20); tick_a = 1'b0; idle(2);
    chk("R4 unselected tick source ignored", bus_rdata, 0);
    cur_req = "R3";
    tick_b = 1'b1; idle(40); tick_b = 1'b0; idle(2);
    chk("R3 one step per four pulses", bus_rdata, 10);
    cur_req = "R6";
    tick_b = 1'b1; idle(2); tick_b = 1'b0;
    wr(2'd2, 16'h0100);
    tick_b = 1'b1; idle(3); tick_b = 1'b0; idle(2);
    chk("R6 load value and phase restarted", bus_rdata, 16'h0100);
    tick_b = 1'b1; idle(1); tick_b = 1'b0; idle(2);
    chk("R6 step after fourth pulse", bus_rdata, 16'h0101);

    // R8 / R9: greater-or-equal on unit 1, event on unit 2
    do_reset();
    cur_req = "R9";
    look(2'd2);
    wr(2'd0, 16'd3); wr(2'd1, 16'd6);
    wr(2'd3, 16'h8380);
    tick_a = 1'b1;
    idle(20);
    pulses = 0;
    for (int i = 0; i < 70; i++) begin
      idle(1);
      if (cmp2_flag) pulses++;
    end
    chk("R9 event flag one cycle per period", pulses, 10);
    cur_req = "R8";
    chk("R8 greater-or-equal flag set", cmp1_flag, 1);
    tick_a = 1'b0; wr(2'd2, 16'd4); idle(1);
    wr(2'd3, 16'h2000); idle(1);
    chk("R8 flag cleared", cmp1_flag, 0);
    tick_a = 1'b1; idle(1); tick_a = 1'b0; idle(1);
    chk("R8 set above compare value", cmp1_flag, 1);

    // R10: both units disabled
    do_reset();
    cur_req = "R10";
    wr(2'd0, 16'd2); wr(2'd1, 16'd4);
    wr(2'd3, 16'h8000);
    tick_a = 1'b1; idle(30);
    chk("R10 disabled flags stay low", {cmp1_flag, cmp2_flag}, 0);

    // R12: reset request
    cur_req = "R12";
    wdt_rst_en = 1'b1; idle(10);
    chk("R12 request raised on compare-2 match", reset_req, 1);
    wdt_rst_en = 1'b0; idle(1);
    chk("R12 request dropped with enable", reset_req, 0);
    tick_a = 1'b0; wdt_rst_en = 1'b1; idle(5);
    chk("R12 no request without a step", reset_req, 0);

    // R1: random traffic against the model
    do_reset();
    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick_a     = ($urandom % 3) != 0;
      tick_b     = ($urandom % 2) != 0;
      if (($urandom % 50) == 0) wdt_rst_en = ~wdt_rst_en;
      bus_wr     = ($urandom % 6) == 0;
      reg_sel    = 2'($urandom);
      bus_wdata  = 16'($urandom % 24);
      if (reg_sel == 2'd3) bus_wdata = 16'($urandom) & 16'hfbc1;
      if (i == 2000) begin
        rst = 1'b1;
      end else rst = 1'b0;
    end
    @(negedge clk);
    bus_wr = 1'b0; rst = 1'b0;
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    done = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule